// File: doc/BRIEF.md
# Return Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small microcontroller core in a fixed set of hardware registers that software cannot reach. A subroutine call pushes the current program counter. An accepted interrupt also pushes it. A return, or a return from an interrupt, pops the newest entry, and the core reloads its program counter from `ret_pc_o`. The output always shows the entry at the top of the stack, so the core can take it in the same cycle that it raises `ret_i`.

The stack also decides when an interrupt may be accepted. A request is latched as pending, and the block refuses to accept it while every level is in use. The first free cycle after a return has opened a level, the pending request is accepted. An accepted request is not held back by a full stack at that point; only a call can still arrive while the stack is full. A call made while the stack is full is not refused. It overwrites the oldest address, so the stack keeps the most recent `DEPTH` return addresses.

Top module: `pc_return_stack`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty_o`=1, `full_o`=0, `irq_ack_o`=0 and `ret_pc_o`=0.
- R2: A cycle with `call_i`=1 and `ret_i`=0 stores `pc_i`, and `ret_pc_o` shows that value from the next cycle on.
- R3: A cycle with `ret_i`=1 on a non-empty stack removes the newest entry, and `ret_pc_o` then shows the entry pushed before it (last in, first out).
- R4: `full_o` is 1 exactly when `DEPTH` entries (default 8) are held, and `empty_o` is 1 exactly when none are held. Both are registered.
- R5: A push while full keeps the level count at `DEPTH` and discards the oldest entry. The following `DEPTH` returns yield the most recent `DEPTH` pushed values, newest first.
- R6: `irq_i` or a pending request raises `irq_ack_o` in the same cycle when the stack is not full and neither `call_i` nor `ret_i` is active. That cycle pushes `pc_i`.
- R7: While `full_o`=1, `irq_ack_o` stays 0 and a request stays pending. The request is acknowledged in the first cycle after a return that has no call or return.
- R8: `ret_i` on an empty stack has no effect: the level stays empty, `ret_pc_o` is unchanged, and a later push and pop behave normally.
- R9: When `call_i` and `ret_i` are both 1, the return is performed and the call is dropped.
- R10: A pending request is not acknowledged in a cycle with `call_i` or `ret_i`. It stays pending until the first cycle without either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call strobe (push request) |
| irq_i | input | 1 | Unmasked interrupt request strobe |
| ret_i | input | 1 | Return or return-from-interrupt strobe (pop) |
| pc_i | input | PC_W | Program counter value to save |
| ret_pc_o | output | PC_W | Entry at the top of the stack (restored program counter) |
| irq_ack_o | output | 1 | Interrupt accepted this cycle |
| full_o | output | 1 | All levels in use |
| empty_o | output | 1 | No level in use |

## Verification
The bench fills the stack to the limit and then keeps calling. A design that refused the extra call, or overwrote the newest entry instead of the oldest, returns the wrong sequence on the way back down. It raises interrupts while the stack is full and checks that they wait, and that the held request is accepted right after a return. A design that acknowledged anyway would push past the limit, and one that lost the latched request would never raise the acknowledge. Returns on an empty stack and collisions of call and return in one cycle are checked as well. Wrong handling there shows up as pointer drift, a changed top entry or a call that sneaks in. These directed cases are mixed with a long random run.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Next slot index, wrapping modulo depth
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Previous slot index, wrapping modulo depth
  function automatic int unsigned wrap_dec(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // Level count after one cycle; pop wins, push saturates at depth
  function automatic int unsigned level_next(int unsigned lvl, bit push, bit pop,
                                             int unsigned depth);
    if (pop)
      return (lvl == 0) ? 0 : lvl - 1;
    if (push)
      return (lvl >= depth) ? depth : lvl + 1;
    return lvl;
  endfunction

endpackage

// File: rtl/ras_storage.sv
module ras_storage #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [PC_W-1:0]  wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [PC_W-1:0]  rdata
);

  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (we && (waddr == PTR_W'(g)))
        slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];

  // R2: a written value lands in the addressed slot
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slot_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] top_idx,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] wp_q;
  logic [LVL_W-1:0] lvl_q;
  logic             full_q, empty_q;
  logic [LVL_W-1:0] lvl_d;
  logic [PTR_W-1:0] wp_d;
  logic             pop_live;   // pop that actually moves the pointer
  logic             push_live;  // push that is not overruled by a pop

  assign pop_live  = pop && !empty_q;
  assign push_live = push && !pop;

  always_comb begin
    lvl_d = LVL_W'(ras_pkg::level_next(32'(lvl_q), push, pop, DEPTH));
    wp_d  = wp_q;
    if (pop_live)
      wp_d = PTR_W'(ras_pkg::wrap_dec(32'(wp_q), DEPTH));
    else if (push_live)
      wp_d = PTR_W'(ras_pkg::wrap_inc(32'(wp_q), DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      lvl_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wp_q    <= wp_d;
      lvl_q   <= lvl_d;
      full_q  <= (lvl_d == LVL_W'(DEPTH));
      empty_q <= (lvl_d == '0);
    end
  end

  assign wr_idx  = wp_q;
  assign top_idx = PTR_W'(ras_pkg::wrap_dec(32'(wp_q), DEPTH));
  assign full    = full_q;
  assign empty   = empty_q;

  // R4: the level never exceeds the depth
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));
  // R4: full and empty are mutually exclusive
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
  // R5: a push while full keeps the stack full
  p_full_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && push && !pop) |=> full_q);
  // R3: a pop on a non-empty stack lowers the level by one
  p_pop_lowers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty_q) |=> lvl_q == $past(lvl_q) - 1'b1);
  // R8: a pop on an empty stack moves nothing
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty_q) |=> (empty_q && $stable(wp_q)));

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic call,
  input  logic ret,
  input  logic full,
  output logic ack,
  output logic pending
);

  logic pend_q;
  logic want;   // a request is live this cycle
  logic busy;   // the stack port is taken by a call or return

  assign want = pend_q || irq;
  assign busy = call || ret;
  assign ack  = want && !full && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else
      pend_q <= want && !ack;
  end

  assign pending = pend_q;

  // R7: no acknowledge while all levels are used
  p_no_ack_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ack);
  // R7: an unserved request is remembered
  p_pend_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (want && !ack) |=> pend_q);
  // R6: an acknowledge always has a request behind it
  p_ack_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (irq || pend_q));
  // R10: never acknowledge in a call or return cycle
  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !(call || ret));

endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            irq_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            irq_ack_o,
  output logic            full_o,
  output logic            empty_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             ack_w;
  logic             pend_w;
  logic             push_w;
  logic             pop_w;
  logic             full_w, empty_w;
  logic [PTR_W-1:0] wr_idx_w, top_idx_w;
  logic             write_w;

  assign pop_w   = ret_i;
  assign push_w  = (call_i || ack_w) && !ret_i;
  assign write_w = push_w;

  ras_irq_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq_i),
    .call    (call_i),
    .ret     (ret_i),
    .full    (full_w),
    .ack     (ack_w),
    .pending (pend_w)
  );

  ras_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push_w),
    .pop     (pop_w),
    .wr_idx  (wr_idx_w),
    .top_idx (top_idx_w),
    .full    (full_w),
    .empty   (empty_w)
  );

  ras_storage #(.PC_W(PC_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (write_w),
    .waddr (wr_idx_w),
    .wdata (pc_i),
    .raddr (top_idx_w),
    .rdata (ret_pc_o)
  );

  assign irq_ack_o = ack_w;
  assign full_o    = full_w;
  assign empty_o   = empty_w;

  // R9: a collision of call and return is a pure pop
  p_ret_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |-> !write_w);
  // R2: a push leaves the stack non-empty
  p_push_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_w |=> !empty_o);
  // R10: a held request survives a busy cycle
  p_pend_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w && (call_i || ret_i)) |=> (pend_w || irq_ack_o || $past(irq_ack_o)) );

endmodule

// File: tb/sim_pc_return_stack.sv
`timescale 1ns/1ps
module sim_pc_return_stack;

  localparam int PC_W  = 13;
  localparam int DEPTH = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            call_i = 1'b0, irq_i = 1'b0, ret_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic [PC_W-1:0] ret_pc_o;
  logic            irq_ack_o, full_o, empty_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic [PC_W-1:0] m_mem [DEPTH];
  int              m_wp  = 0;
  int              m_lvl = 0;
  bit              m_pend = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pc_return_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .irq_i(irq_i), .ret_i(ret_i),
    .pc_i(pc_i), .ret_pc_o(ret_pc_o), .irq_ack_o(irq_ack_o),
    .full_o(full_o), .empty_o(empty_o));

  function automatic int prev_slot(int p);
    return (p == 0) ? DEPTH - 1 : p - 1;
  endfunction

  function automatic int next_slot(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    check(tag, "ret_pc_o", int'(ret_pc_o), int'(m_mem[prev_slot(m_wp)]));
    check(tag, "full_o", int'(full_o), int'(m_lvl == DEPTH));
    check(tag, "empty_o", int'(empty_o), int'(m_lvl == 0));
  endtask

  // one cycle: drive at negedge, check ack, update model at posedge, check state
  task automatic step(bit c, bit q, bit r, logic [PC_W-1:0] pc, string tag);
    bit exp_ack;
    @(negedge clk);
    call_i = c; irq_i = q; ret_i = r; pc_i = pc;
    #1;
    exp_ack = (m_pend || q) && (m_lvl != DEPTH) && !c && !r;
    check(tag, "irq_ack_o", int'(irq_ack_o), int'(exp_ack));
    @(posedge clk);
    if (r) begin
      if (m_lvl > 0) begin
        m_wp = prev_slot(m_wp);
        m_lvl--;
      end
    end else if (c || exp_ack) begin
      m_mem[m_wp] = pc;
      m_wp = next_slot(m_wp);
      if (m_lvl < DEPTH) m_lvl++;
    end
    m_pend = (m_pend || q) && !exp_ack;
    #1;
    check_state(tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

    // R1: reset state
    #5;
    check("R1", "empty_o in reset", int'(empty_o), 1);
    check("R1", "full_o in reset", int'(full_o), 0);
    check("R1", "irq_ack_o in reset", int'(irq_ack_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "ret_pc_o after reset", int'(ret_pc_o), 0);
    check_state("R1");

    // R8: return on empty stack
    step(1'b0, 1'b0, 1'b1, 13'h55, "R8");
    step(1'b0, 1'b0, 1'b1, 13'h55, "R8");

    // R2 / R4: fill up
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b0, 1'b0, PC_W'(13'h100 + i), "R2");
    check("R4", "full after fill", int'(full_o), 1);

    // R7: interrupt while full is held
    step(1'b0, 1'b1, 1'b0, 13'h1AA, "R7");
    idle("R7");
    // R5: call while full discards oldest
    step(1'b1, 1'b0, 1'b0, 13'h0777, "R5");
    step(1'b1, 1'b0, 1'b0, 13'h0778, "R5");
    // R10: return frees a level but ack waits for an idle cycle
    step(1'b0, 1'b0, 1'b1, '0, "R10");
    step(1'b0, 1'b0, 0, 13'h1BB, "R7");   // ack pushes 1BB
    check("R7", "full again after ack", int'(full_o), 1);

    // R3 / R5: unwind all the way
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b0, 1'b1, '0, "R3");
    check("R4", "empty after unwind", int'(empty_o), 1);
    step(1'b0, 1'b0, 1'b1, '0, "R8");

    // R9: collision of call and return
    step(1'b1, 1'b0, 1'b0, 13'h0AB, "R2");
    step(1'b1, 1'b0, 1'b1, 13'h0CD, "R9");
    step(1'b1, 1'b0, 1'b1, 13'h0EF, "R9");

    // R6: interrupt on a free stack is taken at once
    step(1'b0, 1'b1, 1'b0, 13'h0321, "R6");
    // R10: request during a call waits
    step(1'b1, 1'b1, 1'b0, 13'h0400, "R10");
    idle("R10");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      step(sel < 4, ($urandom_range(0, 5) == 0), (sel >= 4 && sel < 7),
           PC_W'($urandom), "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule